// File: doc/BRIEF.md
# PHY Test-Code Configuration Port

This block is the receiving end of a narrow byte-wide configuration port on a PHY. A controller drives a test clock, a test enable, a test clear and eight data pins. The same data pins serve two purposes, chosen by the level of test enable. A falling test-clock edge with enable high loads the byte as the current test code, which acts as an address. A rising test-clock edge with enable low stores the byte into the configuration register that the current code selects. The register that the current code selects is shown on the read-back byte at all times.

All port inputs are asynchronous to the system clock. The block samples them through a synchroniser of `SYNC_STAGES` flops and finds the test-clock edges in the system clock domain. The configuration registers drive the PHY's analogue controls through separate outputs: a clock-lane control byte, one receive-control byte per data lane, the six-bit frequency-range field taken from each lane byte, and a settle-time byte. A small state machine follows the port mode. CLEAR is held while test clear is asserted. NORMAL is entered from reset, when clear is released, or when code 0x00 is loaded. TEST is entered when a nonzero code is loaded. The transitions are CLEAR→NORMAL or CLEAR→TEST when clear drops, NORMAL→TEST when a nonzero code is loaded, TEST→NORMAL when code 0x00 is loaded, and any state→CLEAR when test clear is seen.

Top module: `phy_tcfg_port`

## Requirements
- R1: After reset every configuration output and the read-back byte are 0x00, and `normal_mode` is 1. A test clock that idles high during reset causes no write and no capture.
- R2: A falling edge of `tclk_a` while `ten_a` is high loads `tdin_a` as the current code. `tdout` then shows the register at that code.
- R3: A rising edge of `tclk_a` while `ten_a` is low writes `tdin_a` into the register that the current code selects. The effect is visible within six system clocks of the edge.
- R4: Code 0x34 selects the clock-lane control (`clk_lane_ctrl`), code 0x75 selects the settle-time control (`settle_ctrl`), and codes 0x44, 0x54, 0x84 and 0x94 select data lanes 0 to 3. Lane i occupies `lane_rx_ctrl[8i+7:8i]`.
- R5: `lane_freq_range[6i+5:6i]` equals bits [6:1] of the receive-control byte of lane i.
- R6: Every code other than the seven listed in R4 reads back 0x00. A write to such a code changes no output.
- R7: A rising edge while `ten_a` is high, or a falling edge while `ten_a` is low, changes neither the current code nor any register.
- R8: While `tclr_a` is high, the current code and every configuration register are forced to 0x00.
- R9: `normal_mode` is 1 only in state NORMAL, which holds whenever the current code is 0x00 and test clear is inactive. It is 0 in TEST (nonzero code) and in CLEAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tclk_a | input | 1 | Test clock from the controller, asynchronous |
| ten_a | input | 1 | Test enable, asynchronous: high for code, low for data |
| tclr_a | input | 1 | Test clear, asynchronous, active high |
| tdin_a | input | 8 | Test data in: code or data byte |
| tdout | output | 8 | Register selected by the current code |
| clk_lane_ctrl | output | 8 | Clock-lane receive control |
| lane_rx_ctrl | output | 8*NUM_LANES | Per-lane receive control bytes |
| lane_freq_range | output | 6*NUM_LANES | Per-lane frequency-range fields |
| settle_ctrl | output | 8 | Data-lane settle-time control |
| normal_mode | output | 1 | High in state NORMAL |

## Verification
Two full sweeps cover all 256 codes. Each sweep writes a data byte derived from the code and then reads every code back. The second sweep uses the bit-inverted pattern, so a stuck or crossed data bit in any register is caught, and a wrong address decode is caught when a listed code reads zero or an unlisted code reads nonzero. A stimulus with the edge and enable combination reversed tells a correct edge-to-function mapping apart from one that also reacts to the other edge. Clear and an idle-high test clock at reset are checked separately, which confirms that clearing is complete and that no edge is invented when the synchroniser first fills.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;

    localparam int unsigned TCFG_W = 8;

    localparam logic [TCFG_W-1:0] CODE_NORMAL   = 8'h00;
    localparam logic [TCFG_W-1:0] CODE_CLK_LANE = 8'h34;
    localparam logic [TCFG_W-1:0] CODE_SETTLE   = 8'h75;

    // Data-lane codes: 0x44, 0x54, 0x84, 0x94 for lanes 0..3
    function automatic logic [TCFG_W-1:0] lane_code(input int unsigned idx);
        return TCFG_W'((idx / 2) * 64 + 68 + (idx % 2) * 16);
    endfunction

    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_NORMAL = 2'd1,
        ST_TEST   = 2'd2
    } tcfg_state_e;

endpackage

// File: rtl/tcfg_sync.sv
module tcfg_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tclk_a,
    input  logic          ten_a,
    input  logic          tclr_a,
    input  logic [DW-1:0] tdin_a,
    output logic          rise_ev,
    output logic          fall_ev,
    output logic          ten_s,
    output logic          tclr_s,
    output logic [DW-1:0] tdin_s
);

    localparam int unsigned BW     = DW + 3;
    localparam int unsigned B_TCLK = DW;
    localparam int unsigned B_TEN  = DW + 1;
    localparam int unsigned B_TCLR = DW + 2;

    logic [BW-1:0] pipe [STAGES];
    logic [BW-1:0] bundle_in;
    logic [STAGES:0] fill;
    logic            tclk_prev;
    logic            tclk_s;
    logic            primed;

    assign bundle_in = {tclr_a, ten_a, tclk_a, tdin_a};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe[g] <= '0;
            end else begin
                if (g == 0) begin
                    pipe[g] <= bundle_in;
                end else begin
                    pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
                end
            end
        end
    end

    // Edges are reported only once the whole pipe and the previous-value
    // flop hold real samples, so an idle-high clock gives no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill      <= '0;
            tclk_prev <= 1'b0;
        end else begin
            fill      <= {fill[STAGES-1:0], 1'b1};
            tclk_prev <= tclk_s;
        end
    end

    assign primed  = fill[STAGES];
    assign tclk_s  = pipe[STAGES-1][B_TCLK];
    assign ten_s   = pipe[STAGES-1][B_TEN];
    assign tclr_s  = pipe[STAGES-1][B_TCLR];
    assign tdin_s  = pipe[STAGES-1][DW-1:0];
    assign rise_ev = primed &  tclk_s & ~tclk_prev;
    assign fall_ev = primed & ~tclk_s &  tclk_prev;

endmodule

// File: rtl/tcfg_ctrl.sv
module tcfg_ctrl
    import tcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              ten_s,
    input  logic              tclr_s,
    input  logic [TCFG_W-1:0] tdin_s,
    output logic [TCFG_W-1:0] code,
    output logic              wr_en,
    output logic              normal_mode,
    output tcfg_state_e       state
);

    tcfg_state_e state_nxt;
    logic        cap;
    logic        cap_zero;

    assign cap      = fall_ev & ten_s & ~tclr_s;
    assign cap_zero = (tdin_s == CODE_NORMAL);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_NORMAL;
        end else begin
            state <= state_nxt;
        end
    end

    // Code register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= CODE_NORMAL;
        end else if (tclr_s) begin
            code <= CODE_NORMAL;
        end else if (cap) begin
            code <= tdin_s;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (tclr_s) begin
            state_nxt = ST_CLEAR;
        end else begin
            unique case (state)
                ST_CLEAR: begin
                    if (cap && !cap_zero) state_nxt = ST_TEST;
                    else                  state_nxt = ST_NORMAL;
                end
                ST_NORMAL: begin
                    if (cap && !cap_zero) state_nxt = ST_TEST;
                end
                ST_TEST: begin
                    if (cap && cap_zero) state_nxt = ST_NORMAL;
                end
                default: state_nxt = ST_CLEAR;
            endcase
        end
    end

    // Outputs
    always_comb begin
        normal_mode = 1'b0;
        wr_en       = 1'b0;
        unique case (state)
            ST_CLEAR: begin
                normal_mode = 1'b0;
                wr_en       = 1'b0;
            end
            ST_NORMAL: begin
                normal_mode = 1'b1;
                wr_en       = rise_ev & ~ten_s & ~tclr_s;
            end
            ST_TEST: begin
                normal_mode = 1'b0;
                wr_en       = rise_ev & ~ten_s & ~tclr_s;
            end
            default: begin
                normal_mode = 1'b0;
                wr_en       = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tcfg_regs.sv
module tcfg_regs
    import tcfg_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic [TCFG_W-1:0]           code,
    input  logic [TCFG_W-1:0]           wdata,
    output logic [TCFG_W-1:0]           clk_lane_q,
    output logic [NUM_LANES*TCFG_W-1:0] lane_q,
    output logic [TCFG_W-1:0]           settle_q,
    output logic [TCFG_W-1:0]           rdata
);

    logic [NUM_LANES-1:0] lane_hit;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            clk_lane_q <= '0;
        end else if (wr_en && code == CODE_CLK_LANE) begin
            clk_lane_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            settle_q <= '0;
        end else if (wr_en && code == CODE_SETTLE) begin
            settle_q <= wdata;
        end
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign lane_hit[i] = (code == lane_code(i));
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lane_q[i*TCFG_W +: TCFG_W] <= '0;
            end else if (wr_en && lane_hit[i]) begin
                lane_q[i*TCFG_W +: TCFG_W] <= wdata;
            end
        end
    end

    // Read-back: unlisted codes give zero
    always_comb begin
        rdata = '0;
        if (code == CODE_CLK_LANE) rdata = clk_lane_q;
        if (code == CODE_SETTLE)   rdata = settle_q;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (lane_hit[i]) rdata = lane_q[i*TCFG_W +: TCFG_W];
        end
    end

endmodule

// File: rtl/phy_tcfg_port.sv
module phy_tcfg_port
    import tcfg_pkg::*;
#(
    parameter int unsigned NUM_LANES   = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FREQ_LSB    = 1,
    parameter int unsigned FREQ_W      = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tclk_a,
    input  logic                        ten_a,
    input  logic                        tclr_a,
    input  logic [TCFG_W-1:0]           tdin_a,
    output logic [TCFG_W-1:0]           tdout,
    output logic [TCFG_W-1:0]           clk_lane_ctrl,
    output logic [NUM_LANES*TCFG_W-1:0] lane_rx_ctrl,
    output logic [NUM_LANES*FREQ_W-1:0] lane_freq_range,
    output logic [TCFG_W-1:0]           settle_ctrl,
    output logic                        normal_mode
);

    logic              rise_ev;
    logic              fall_ev;
    logic              ten_s;
    logic              tclr_s;
    logic [TCFG_W-1:0] tdin_s;
    logic [TCFG_W-1:0] code;
    logic              wr_en;
    tcfg_state_e       state;

    tcfg_sync #(
        .STAGES (SYNC_STAGES),
        .DW     (TCFG_W)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tclk_a  (tclk_a),
        .ten_a   (ten_a),
        .tclr_a  (tclr_a),
        .tdin_a  (tdin_a),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .ten_s   (ten_s),
        .tclr_s  (tclr_s),
        .tdin_s  (tdin_s)
    );

    tcfg_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_ev     (rise_ev),
        .fall_ev     (fall_ev),
        .ten_s       (ten_s),
        .tclr_s      (tclr_s),
        .tdin_s      (tdin_s),
        .code        (code),
        .wr_en       (wr_en),
        .normal_mode (normal_mode),
        .state       (state)
    );

    tcfg_regs #(
        .NUM_LANES (NUM_LANES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (tclr_s),
        .wr_en      (wr_en),
        .code       (code),
        .wdata      (tdin_s),
        .clk_lane_q (clk_lane_ctrl),
        .lane_q     (lane_rx_ctrl),
        .settle_q   (settle_ctrl),
        .rdata      (tdout)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_freq
        assign lane_freq_range[i*FREQ_W +: FREQ_W] =
            lane_rx_ctrl[i*TCFG_W + FREQ_LSB +: FREQ_W];
    end

endmodule

// File: rtl/tcfg_checker.sv
module tcfg_checker
    import tcfg_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rise_ev,
    input logic                        fall_ev,
    input logic                        ten_s,
    input logic                        tclr_s,
    input logic [TCFG_W-1:0]           code,
    input logic [TCFG_W-1:0]           tdout,
    input logic [TCFG_W-1:0]           clk_lane_ctrl,
    input logic [NUM_LANES*TCFG_W-1:0] lane_rx_ctrl,
    input logic [TCFG_W-1:0]           settle_ctrl,
    input logic                        normal_mode
);

    function automatic logic listed(input logic [TCFG_W-1:0] c);
        logic hit;
        hit = (c == CODE_CLK_LANE) || (c == CODE_SETTLE);
        for (int i = 0; i < NUM_LANES; i++) begin
            if (c == lane_code(i)) hit = 1'b1;
        end
        return hit;
    endfunction

    // R7 / R2: the code moves only on an enabled falling edge or a clear
    p_code_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> $past((fall_ev && ten_s) || tclr_s));

    // R3: the settle byte moves only on a data write to its code or a clear
    p_settle_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_ctrl != $past(settle_ctrl)) |->
            $past((rise_ev && !ten_s && code == CODE_SETTLE) || tclr_s));

    // R4: the clock-lane byte moves only on a write to code 0x34 or a clear
    p_clklane_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_lane_ctrl != $past(clk_lane_ctrl)) |->
            $past((rise_ev && !ten_s && code == CODE_CLK_LANE) || tclr_s));

    // R8: a clear empties code and registers on the next cycle
    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tclr_s |=> (code == CODE_NORMAL && clk_lane_ctrl == '0 &&
                    settle_ctrl == '0 && lane_rx_ctrl == '0));

    // R9: normal mode implies code 0x00
    p_normal_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        normal_mode |-> (code == CODE_NORMAL));

    // R6: nonzero read-back only at a listed code
    p_unlisted_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tdout != '0) |-> listed(code));

endmodule

bind phy_tcfg_port tcfg_checker #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rise_ev       (rise_ev),
    .fall_ev       (fall_ev),
    .ten_s         (ten_s),
    .tclr_s        (tclr_s),
    .code          (code),
    .tdout         (tdout),
    .clk_lane_ctrl (clk_lane_ctrl),
    .lane_rx_ctrl  (lane_rx_ctrl),
    .settle_ctrl   (settle_ctrl),
    .normal_mode   (normal_mode)
);

// File: tb/phy_tcfg_port_bench.sv
`timescale 1ns/1ps
module phy_tcfg_port_bench;

    localparam int NL   = 4;
    localparam int STEP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tclk_a = 1'b1;
    logic          ten_a = 1'b0;
    logic          tclr_a = 1'b0;
    logic [7:0]    tdin_a = 8'h00;
    logic [7:0]    tdout;
    logic [7:0]    clk_lane_ctrl;
    logic [NL*8-1:0] lane_rx_ctrl;
    logic [NL*6-1:0] lane_freq_range;
    logic [7:0]    settle_ctrl;
    logic          normal_mode;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] mdl [256];

    always #2.5 clk = ~clk;

    phy_tcfg_port u_phy_tcfg_port (
        .clk             (clk),
        .rst_n           (rst_n),
        .tclk_a          (tclk_a),
        .ten_a           (ten_a),
        .tclr_a          (tclr_a),
        .tdin_a          (tdin_a),
        .tdout           (tdout),
        .clk_lane_ctrl   (clk_lane_ctrl),
        .lane_rx_ctrl    (lane_rx_ctrl),
        .lane_freq_range (lane_freq_range),
        .settle_ctrl     (settle_ctrl),
        .normal_mode     (normal_mode)
    );

    function automatic logic [7:0] lane_addr(input int i);
        case (i)
            0: return 8'h44;
            1: return 8'h54;
            2: return 8'h84;
            default: return 8'h94;
        endcase
    endfunction

    function automatic logic is_listed(input int c);
        if (c == 8'h34 || c == 8'h75) return 1'b1;
        for (int i = 0; i < NL; i++) if (c == lane_addr(i)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (STEP) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] c, input logic [7:0] d);
        tdin_a = c; ten_a = 1'b1; settle();
        tclk_a = 1'b0; settle();
        ten_a = 1'b0; settle();
        tdin_a = d; settle();
        tclk_a = 1'b1; settle();
        if (is_listed(int'(c))) mdl[c] = d;
    endtask

    task automatic sel(input logic [7:0] c);
        tdin_a = c; ten_a = 1'b1; settle();
        tclk_a = 1'b0; settle();
        tclk_a = 1'b1; settle();
        ten_a = 1'b0; settle();
    endtask

    task automatic check_outputs(input string req);
        chk({req, " clk_lane_ctrl"}, 32'(clk_lane_ctrl), 32'(mdl[8'h34]));
        chk({req, " settle_ctrl"}, 32'(settle_ctrl), 32'(mdl[8'h75]));
        for (int i = 0; i < NL; i++) begin
            chk({req, " lane_rx_ctrl"}, 32'(lane_rx_ctrl[i*8 +: 8]), 32'(mdl[lane_addr(i)]));
            chk("R5 lane_freq_range", 32'(lane_freq_range[i*6 +: 6]),
                32'((mdl[lane_addr(i)] >> 1) & 8'h3F));
        end
    endtask

    task automatic sweep(input logic inv);
        for (int c = 0; c < 256; c++) begin
            logic [7:0] d;
            d = 8'((c * 7 + 1) & 255);
            if (inv) d = ~d;
            wr(8'(c), d);
        end
        check_outputs("R4");
        for (int c = 0; c < 256; c++) begin
            sel(8'(c));
            if (is_listed(c)) chk("R3 readback", 32'(tdout), 32'(mdl[c]));
            else              chk("R6 unlisted readback", 32'(tdout), 32'h0);
            chk("R9 normal_mode vs code", 32'(normal_mode), 32'(c == 0));
        end
        check_outputs("R6");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1: reset state, idle-high clock made no edge
        chk("R1 tdout", 32'(tdout), 32'h0);
        chk("R1 normal_mode", 32'(normal_mode), 32'h1);
        check_outputs("R1");

        // R2: capture a code then see its register
        wr(8'h34, 8'hA5);
        chk("R2 code capture readback", 32'(tdout), 32'hA5);
        chk("R9 test mode", 32'(normal_mode), 32'h0);

        // R7: reversed edge/enable combinations are ignored
        sel(8'h44);
        wr(8'h44, 8'h3C);
        tdin_a = 8'h34; settle();
        tclk_a = 1'b0; settle();              // falling edge, enable low
        tdin_a = 8'h99; ten_a = 1'b1; settle();
        tclk_a = 1'b1; settle();              // rising edge, enable high
        ten_a = 1'b0; settle();
        chk("R7 code unchanged", 32'(tdout), 32'h3C);
        chk("R7 lane0 not written", 32'(lane_rx_ctrl[7:0]), 32'h3C);
        chk("R7 clk lane not written", 32'(clk_lane_ctrl), 32'hA5);

        sweep(1'b0);
        sweep(1'b1);

        // R8: clear
        sel(8'h75);
        tclr_a = 1'b1; settle();
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        chk("R8 tdout during clear", 32'(tdout), 32'h0);
        chk("R9 normal_mode in clear", 32'(normal_mode), 32'h0);
        check_outputs("R8");
        tclr_a = 1'b0; settle();
        chk("R9 normal after clear", 32'(normal_mode), 32'h1);
        sel(8'h75);
        chk("R8 settle cleared", 32'(tdout), 32'h0);
        wr(8'h94, 8'h7E);
        check_outputs("R4 after clear");
        sel(8'h00);
        chk("R9 back to normal", 32'(normal_mode), 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 run hung actual=%0d expected=%0d", 190000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule